// File: doc/BRIEF.md
# Bus Master Reset Quiesce Logic

This block sits inside one translation unit of a bus bridge and brings its bus activity to a clean stop before an internal reset. A sideband input announces that the reset is coming. From then on the outbound master side raises no new bus request, and it withdraws a request that has not yet been granted. A transfer that is already running may end the normal way, when the target ends it or the data runs out. If the target retries or disconnects that transfer, the master does not start it again. The inbound target side stops claiming new transactions, so their initiators see a master abort. The one exception is the configuration cycle that set the reset bit: that cycle is still claimed and finished.

Once the outbound side is quiet and no reset-setting configuration cycle is outstanding, the block raises a ready-for-reset flag. The flag holds until reset is applied. Reset clears every pending interrupt and returns the unit's small register bank to its default values.

Top module: `rqa_quiesce_top`

## Requirements
- R1: While `rst_notice` is high, `mst_req` and `mst_start` stay low, even when a request was pending and `mst_gnt` is high in the same cycle.
- R2: An idle master with `mst_want` high raises `mst_req` one cycle after `mst_want` rises if `rst_notice` is low. If `rst_notice` is high it never raises `mst_req`.
- R3: A transfer that is running when `rst_notice` rises is not cut short. `rst_ready` stays low until the cycle after the one in which `mst_done` is sampled.
- R4: When `mst_stop` (retry or disconnect) ends a transfer and `rst_notice` is low, `mst_req` is high again in the next cycle. When `rst_notice` is high, the transfer is not reissued and `mst_req` stays low.
- R5: `tgt_claim` follows `tgt_hit` while `rst_notice` is low. While `rst_notice` is high, a hit that is not the reset-setting configuration cycle is not claimed.
- R6: `rst_ready` rises one cycle after a cycle in which three things hold together: `rst_notice` is high, no transfer is running, and `tgt_cfg` is low.
- R7: Once high, `rst_ready` stays high until reset, whatever `rst_notice` does.
- R8: While `rst_n` is low, `rst_ready`, `irq_out` and `irq_pend` are 0. Register i returns to `DEF_SEED ^ (i * 'h111)`, truncated to `REG_W` bits (defaults 'hA5C3, 'hA4D2, 'hA7E1, 'hA6F0 for registers 0 to 3).
- R9: A hit marked by `tgt_cfg` (the configuration cycle that set the reset bit) is claimed even while `rst_notice` is high.
- R10: A 1 on bit k of `irq_evt` sets bit k of `irq_pend` in the next cycle. A 1 on bit k of `irq_ack` clears it, and the event wins if both are high. `irq_out` is the OR of `irq_pend`.
- R11: A write with `wr_en` stores `wr_data` at `wr_addr`. A read with `rd_en` returns the register at `rd_addr` on `rd_data`, with `rd_valid` high, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_notice | input | 1 | Sideband notice that an internal reset is coming |
| mst_want | input | 1 | Outbound work is waiting for the bus |
| mst_gnt | input | 1 | Bus grant |
| mst_stop | input | 1 | Target retry or disconnect ended the transfer |
| mst_done | input | 1 | Transfer ended naturally |
| mst_req | output | 1 | Bus request |
| mst_start | output | 1 | Transfer starts this cycle |
| tgt_hit | input | 1 | Inbound transaction decodes to this unit |
| tgt_cfg | input | 1 | The hit is the configuration cycle that set the reset bit |
| tgt_claim | output | 1 | Claim the inbound transaction |
| rst_ready | output | 1 | Ready-for-reset, sticky until reset |
| irq_evt | input | NUM_IRQ | Interrupt source events |
| irq_ack | input | NUM_IRQ | Interrupt acknowledge, one bit per source |
| irq_pend | output | NUM_IRQ | Pending interrupts |
| irq_out | output | 1 | OR of pending interrupts |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | REG_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | REG_W | Read data, one cycle after rd_en |
| rd_valid | output | 1 | rd_data is valid |

## Verification
The bench builds the block with its defaults: four interrupt sources and four 16-bit registers with seed 'hA5C3. With these values every register default and every interrupt bit can be reached and compared. The master is driven through each place it can stand when the notice arrives: idle, request pending, grant in the same cycle, running to a natural end, and ended by a retry. The inbound side is driven with ordinary hits and with the reset-setting configuration cycle, with the notice both low and high.

// File: rtl/rqa_pkg.sv
package rqa_pkg;
   typedef enum logic [1:0] {
      M_IDLE = 2'd0,
      M_REQ  = 2'd1,
      M_BUSY = 2'd2
   } mst_st_e;

   function automatic logic [31:0] reg_default(input int unsigned idx, input logic [31:0] seed);
      return seed ^ (idx * 32'h0000_0111);
   endfunction
endpackage

// File: rtl/rqa_master_fsm.sv
module rqa_master_fsm
   import rqa_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic notice,
   input  logic want,
   input  logic gnt,
   input  logic stop,
   input  logic done,
   output logic req,
   output logic start,
   output logic quiet
);
   mst_st_e st_q, st_d;

   assign req   = (st_q == M_REQ) && !notice;
   assign start = req && gnt;
   assign quiet = (st_q != M_BUSY);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         M_IDLE: if (want && !notice) st_d = M_REQ;
         M_REQ: begin
            if (notice)     st_d = M_IDLE;
            else if (gnt)   st_d = M_BUSY;
         end
         M_BUSY: begin
            if (done)       st_d = M_IDLE;
            else if (stop)  st_d = notice ? M_IDLE : M_REQ;
         end
         default:           st_d = M_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= M_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/rqa_target_gate.sv
module rqa_target_gate (
   input  logic notice,
   input  logic hit,
   input  logic cfg,
   output logic claim,
   output logic quiet
);
   assign claim = hit && (!notice || cfg);
   assign quiet = !cfg;
endmodule

// File: rtl/rqa_irq_regs.sv
module rqa_irq_regs
   import rqa_pkg::*;
#(
   parameter int unsigned NUM_IRQ  = 4,
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned REG_W    = 16,
   parameter logic [31:0] DEF_SEED = 32'h0000_A5C3,
   localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_evt,
   input  logic [NUM_IRQ-1:0] irq_ack,
   output logic [NUM_IRQ-1:0] irq_pend,
   output logic               irq_out,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [REG_W-1:0]   rd_data,
   output logic               rd_valid
);
   logic [NUM_REGS*REG_W-1:0] flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_pend <= '0;
      else        irq_pend <= (irq_pend & ~irq_ack) | irq_evt;
   end
   assign irq_out = |irq_pend;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [31:0]      DEF32 = reg_default(g, DEF_SEED);
      localparam logic [REG_W-1:0] DEF   = DEF32[REG_W-1:0];
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= DEF;
         else if (wr_en && wr_addr == ADDR_W'(g))  q <= wr_data;
      end
      assign flat[g*REG_W +: REG_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            if (32'(rd_addr) < NUM_REGS) rd_data <= flat[rd_addr*REG_W +: REG_W];
            else                         rd_data <= '0;
         end
      end
   end
endmodule

// File: rtl/rqa_quiesce_top.sv
module rqa_quiesce_top #(
   parameter int unsigned NUM_IRQ  = 4,
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned REG_W    = 16,
   parameter logic [31:0] DEF_SEED = 32'h0000_A5C3,
   localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_notice,
   input  logic               mst_want,
   input  logic               mst_gnt,
   input  logic               mst_stop,
   input  logic               mst_done,
   output logic               mst_req,
   output logic               mst_start,
   input  logic               tgt_hit,
   input  logic               tgt_cfg,
   output logic               tgt_claim,
   output logic               rst_ready,
   input  logic [NUM_IRQ-1:0] irq_evt,
   input  logic [NUM_IRQ-1:0] irq_ack,
   output logic [NUM_IRQ-1:0] irq_pend,
   output logic               irq_out,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [REG_W-1:0]   rd_data,
   output logic               rd_valid
);
   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_irq
      $error("NUM_IRQ must be 1..32");
   end
   if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_regs
      $error("NUM_REGS must be 1..256");
   end
   if (REG_W < 1 || REG_W > 32) begin : g_bad_w
      $error("REG_W must be 1..32");
   end

   logic ob_quiet, ib_quiet;

   rqa_master_fsm u_mst (
      .clk(clk), .rst_n(rst_n), .notice(rst_notice), .want(mst_want),
      .gnt(mst_gnt), .stop(mst_stop), .done(mst_done),
      .req(mst_req), .start(mst_start), .quiet(ob_quiet)
   );

   rqa_target_gate u_tgt (
      .notice(rst_notice), .hit(tgt_hit), .cfg(tgt_cfg),
      .claim(tgt_claim), .quiet(ib_quiet)
   );

   rqa_irq_regs #(
      .NUM_IRQ(NUM_IRQ), .NUM_REGS(NUM_REGS), .REG_W(REG_W), .DEF_SEED(DEF_SEED)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .irq_ack(irq_ack),
      .irq_pend(irq_pend), .irq_out(irq_out),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_ready <= 1'b0;
      else        rst_ready <= rst_ready | (rst_notice & ob_quiet & ib_quiet);
   end
endmodule

// File: rtl/rqa_quiesce_chk.sv
module rqa_quiesce_chk #(
   parameter int unsigned NUM_IRQ  = 4,
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned REG_W    = 16,
   localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rst_notice,
   input logic               mst_want,
   input logic               mst_gnt,
   input logic               mst_stop,
   input logic               mst_done,
   input logic               mst_req,
   input logic               mst_start,
   input logic               tgt_hit,
   input logic               tgt_cfg,
   input logic               tgt_claim,
   input logic               rst_ready,
   input logic [NUM_IRQ-1:0] irq_evt,
   input logic [NUM_IRQ-1:0] irq_ack,
   input logic [NUM_IRQ-1:0] irq_pend,
   input logic               irq_out,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [REG_W-1:0]   wr_data,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [REG_W-1:0]   rd_data,
   input logic               rd_valid
);
   p_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_notice |-> !mst_start);
   p_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_notice |-> !mst_req);
   p_no_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_notice && mst_stop) |=> !mst_req);
   p_no_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_notice && !tgt_cfg) |-> !tgt_claim);
   p_rdy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_ready) |-> $past(rst_notice && !tgt_cfg));
   p_rdy_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ready |=> rst_ready);
   p_cfg_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_hit && tgt_cfg) |-> tgt_claim);
   p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_evt) |=> irq_out);
   p_rd_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r8: assert (!rst_ready && !irq_out && irq_pend == '0);
      end
   end
endmodule

bind rqa_quiesce_top rqa_quiesce_chk #(
   .NUM_IRQ(NUM_IRQ), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
) chk_i (.*);

// File: tb/rqa_quiesce_top_tb_top.sv
module rqa_quiesce_top_tb_top;
   localparam int unsigned NI = 4;
   localparam int unsigned NR = 4;
   localparam int unsigned RW = 16;
   localparam int unsigned AW = 2;
   localparam logic [31:0] SEED = 32'h0000_A5C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rst_notice = 0, mst_want = 0, mst_gnt = 0, mst_stop = 0, mst_done = 0;
   logic mst_req, mst_start;
   logic tgt_hit = 0, tgt_cfg = 0, tgt_claim, rst_ready;
   logic [NI-1:0] irq_evt = '0, irq_ack = '0, irq_pend;
   logic irq_out;
   logic wr_en = 0, rd_en = 0, rd_valid;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [RW-1:0] wr_data = '0, rd_data;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;
   logic [RW-1:0] exp_q[$];

   always #2 clk = ~clk;

   rqa_quiesce_top #(.NUM_IRQ(NI), .NUM_REGS(NR), .REG_W(RW), .DEF_SEED(SEED)) dut_i (.*);

   function automatic logic [RW-1:0] dflt(input int i);
      logic [31:0] v;
      v = SEED ^ (32'(i) * 32'h111);
      return v[RW-1:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11 actual=%0h expected=none", rd_data);
         end else begin
            check("R11 read", 32'(rd_data), 32'(exp_q.pop_front()));
         end
      end
   end

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic rd(input int a, input logic [RW-1:0] e);
      exp_q.push_back(e);
      rd_en = 1; rd_addr = AW'(a);
      cyc();
      rd_en = 0;
      cyc();
   endtask

   task automatic do_reset();
      rst_notice = 0; mst_want = 0; mst_gnt = 0; mst_stop = 0; mst_done = 0;
      tgt_hit = 0; tgt_cfg = 0; irq_evt = '0; irq_ack = '0;
      rst_n = 0;
      #1;
      check("R8 ready cleared", 32'(rst_ready), 0);
      check("R8 irq cleared", 32'(irq_pend), 0);
      cyc();
      rst_n = 1;
      cyc();
   endtask

   initial begin
      repeat (1000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      check("R8 reset req", 32'(mst_req), 0);
      check("R8 reset ready", 32'(rst_ready), 0);
      check("R8 reset irq", 32'(irq_out), 0);
      rst_n = 1;
      cyc();
      for (int i = 0; i < NR; i++) rd(i, dflt(i));

      // normal flow, no notice
      mst_want = 1; cyc();
      #1 check("R2 request raised", 32'(mst_req), 1);
      mst_gnt = 1; #1 check("R2 start on grant", 32'(mst_start), 1);
      cyc(); mst_gnt = 0; mst_want = 0;
      #1 check("R2 busy no req", 32'(mst_req), 0);
      mst_stop = 1; cyc(); mst_stop = 0;
      #1 check("R4 retry re-requests", 32'(mst_req), 1);
      mst_gnt = 1; cyc(); mst_gnt = 0;
      mst_done = 1; cyc(); mst_done = 0;
      #1 check("R3 idle after done", 32'(mst_req), 0);

      // pending request withdrawn
      mst_want = 1; cyc();
      #1 check("R1 pending req", 32'(mst_req), 1);
      rst_notice = 1; mst_gnt = 1;
      #1 check("R1 req withdrawn", 32'(mst_req), 0);
      check("R1 no start", 32'(mst_start), 0);
      cyc(); mst_gnt = 0;
      check("R6 ready after withdraw", 32'(rst_ready), 1);
      for (int i = 0; i < 3; i++) begin
         cyc();
         #1 check("R2 no req after notice", 32'(mst_req), 0);
      end
      rst_notice = 0; cyc(); cyc();
      check("R7 ready sticky", 32'(rst_ready), 1);
      do_reset();

      // running transfer finishes
      mst_want = 1; cyc(); mst_gnt = 1; cyc(); mst_gnt = 0; mst_want = 0;
      rst_notice = 1; cyc(); cyc();
      check("R3 ready waits busy", 32'(rst_ready), 0);
      mst_done = 1; cyc(); mst_done = 0;
      check("R3 ready not yet", 32'(rst_ready), 0);
      cyc();
      check("R3 ready after done", 32'(rst_ready), 1);
      do_reset();

      // retry after notice not reissued
      mst_want = 1; cyc(); mst_gnt = 1; cyc(); mst_gnt = 0;
      rst_notice = 1; mst_stop = 1; cyc(); mst_stop = 0;
      for (int i = 0; i < 3; i++) begin
         #1 check("R4 no reissue", 32'(mst_req), 0);
         cyc();
      end
      check("R6 ready after stop", 32'(rst_ready), 1);
      do_reset();

      // inbound side
      tgt_hit = 1;
      #1 check("R5 claim before notice", 32'(tgt_claim), 1);
      rst_notice = 1;
      #1 check("R5 no claim after notice", 32'(tgt_claim), 0);
      tgt_cfg = 1;
      #1 check("R9 cfg cycle claimed", 32'(tgt_claim), 1);
      cyc(); cyc();
      check("R6 ready waits cfg", 32'(rst_ready), 0);
      tgt_hit = 0; tgt_cfg = 0; cyc();
      check("R6 ready after cfg", 32'(rst_ready), 1);
      do_reset();

      // interrupts and registers
      irq_evt = 4'b0101; cyc(); irq_evt = '0;
      check("R10 pend set", 32'(irq_pend), 32'h5);
      check("R10 irq out", 32'(irq_out), 1);
      irq_ack = 4'b0001; cyc(); irq_ack = '0;
      check("R10 ack clears", 32'(irq_pend), 32'h4);
      irq_ack = 4'b0010; irq_evt = 4'b0010; cyc(); irq_ack = '0; irq_evt = '0;
      check("R10 event wins", 32'(irq_pend), 32'h6);
      wr_en = 1; wr_addr = 2'd1; wr_data = 16'h1234; cyc(); wr_en = 0;
      rd(1, 16'h1234);
      rd(2, dflt(2));
      do_reset();
      check("R8 irq out cleared", 32'(irq_out), 0);
      rd(1, dflt(1));
      cyc();
      check("R11 scoreboard drained", 32'(exp_q.size()), 0);

      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule